// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits between the write qualification logic of a byte-wide nonvolatile memory and its page write controller. It watches each qualified byte write (a 15-bit address and an 8-bit data value). It picks out the fixed address/data command sequences that turn software write protection on, unlock a single page burst while protection is on, or turn protection off. For every write it tells the page controller one of three things: store the byte, drop it because it is a command byte, or drop it because the array is protected and no unlock preceded it. A dropped protected write still starts the controller's write timers; that timing belongs to the controller.

The protection flag models a nonvolatile bit, so the ordinary reset does not clear it. A separate factory-init input puts it in its shipped, unprotected state. Changes requested by a command sequence are held as pending until the end of the page write period that follows. The page controller marks that point with a one-cycle strobe, and the change lands there even if no data bytes followed the command. The unlock window opened by a command also closes at that strobe.

Top module: `wpseq_top`

## Requirements
- R1: With `wrValid` low, `commitOk` and `swallow` are both low. With `wrValid` high, both flags are combinational on the same cycle's inputs, and they are never high together.
- R2: The unlock/arm prefix is three writes: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Each of these bytes gives `swallow`=1 and `commitOk`=0. Every write after the prefix gives `commitOk`=1 until the next `pageEnd`.
- R3: After the arm prefix, `protOn` reads 1 from the clock edge that samples the following `pageEnd`. This holds even when no data byte came between the prefix and the strobe. Before that edge `protOn` keeps its old value.
- R4: While `protOn`=1 and no unlock window is open, a write outside a command sequence gives `commitOk`=0 and `swallow`=0.
- R5: The clear sequence is six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. All six are swallowed, and later writes commit until `pageEnd`. `protOn` reads 0 from the edge that samples that `pageEnd`.
- R6: A write that does not match the next expected step sends the detector back to idle. That write is not swallowed and is qualified as plain data: `commitOk`=1 when `protOn`=0 and `commitOk`=0 when `protOn`=1. It does not start a new sequence.
- R7: The unlock window closes at `pageEnd`. A later protected write without a fresh prefix is blocked. A partial sequence pending at `pageEnd` is discarded, so its next step afterwards counts as plain data.
- R8: Inside an open window every write is data: bytes that match a command pattern commit and are not swallowed.
- R9: `rst_n` low clears the detector, the unlock window and any pending change, but leaves `protOn` unchanged. `factoryInit` high sets `protOn` to 0 at the next clock edge, whether or not reset is asserted.
- R10: `protOn` changes only at an edge where `pageEnd` or `factoryInit` was high.
- R11: With `protOn`=0, every write that is not swallowed commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the detector (not of `protOn`) |
| factoryInit | input | 1 | Synchronous clear of the protection flag to the shipped state |
| wrValid | input | 1 | A qualified byte write is present this cycle |
| wrAddr | input | 15 | Byte address of the write |
| wrData | input | 8 | Byte value of the write |
| pageEnd | input | 1 | One-cycle strobe at the end of a page write period |
| commitOk | output | 1 | The current write may be stored |
| swallow | output | 1 | The current write is a command byte and must not be stored |
| protOn | output | 1 | Software write protection is active |

## Verification
The bench covers protection being armed or cleared by a sequence that no data byte follows. A design that waited for data would leave `protOn` unchanged. A design that applied the change at once would move `protOn` before the strobe. The bench breaks sequences at their second step under both protection states. A wrong design would swallow the breaking byte, store it while protected, or let it restart a sequence. It also writes command patterns inside an open window and checks that they are stored rather than dropped. Reset arrives mid-window and with a clear pending; a design that let either survive, or that reset the protection flag, would fail the checks that follow.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;

  // detector position inside the command grammar
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // waiting for first key byte
    ST_KEY1  = 3'd1,  // first key byte seen
    ST_KEY2  = 3'd2,  // second key byte seen, arm or erase may follow
    ST_DKEY1 = 3'd3,  // erase code seen, second key pair starts
    ST_DKEY2 = 3'd4,  // second pair, first byte seen
    ST_DKEY3 = 3'd5,  // second pair complete, clear code may follow
    ST_OPEN  = 3'd6   // unlock window: all writes are data
  } seqState_t;

  // indices into the pattern-hit vector
  localparam int HIT_KEYA  = 0;
  localparam int HIT_KEYB  = 1;
  localparam int HIT_ARM   = 2;
  localparam int HIT_ERASE = 3;
  localparam int HIT_CLEAR = 4;
  localparam int NUM_PATS  = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic armSet;     // arm prefix completed this cycle
    logic clearSet;   // clear sequence completed this cycle
    logic periodEnd;  // page write period ends this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/wpseq_datapath.sv
module wpseq_datapath
  import wpseq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA,
  parameter logic [DATA_W-1:0] CODE_KEYA = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_KEYB = 8'h55,
  parameter logic [DATA_W-1:0] CODE_ARM = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_ERASE = 8'h80,
  parameter logic [DATA_W-1:0] CODE_CLEAR = 8'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                factoryInit,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  ctrlStrobe_t         strobe,
  output logic [NUM_PATS-1:0] patHit,
  output logic                protOn
);

  localparam int PAT_AW = NUM_PATS * ADDR_W;
  localparam int PAT_DW = NUM_PATS * DATA_W;

  // pattern table, entry i at bits [i*W +: W], order follows HIT_* indices
  localparam logic [PAT_AW-1:0] PAT_ADDR = {ADDR_HI, ADDR_HI, ADDR_HI, ADDR_LO, ADDR_HI};
  localparam logic [PAT_DW-1:0] PAT_DATA = {CODE_CLEAR, CODE_ERASE, CODE_ARM, CODE_KEYB, CODE_KEYA};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PATS; gi++) begin : g_pat
      assign patHit[gi] = (wrAddr == PAT_ADDR[gi*ADDR_W +: ADDR_W]) &&
                          (wrData == PAT_DATA[gi*DATA_W +: DATA_W]);
    end
  endgenerate

  logic armPend;
  logic clearPend;

  // requested change, held until the page period closes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armPend   <= 1'b0;
      clearPend <= 1'b0;
    end else if (strobe.periodEnd) begin
      armPend   <= 1'b0;
      clearPend <= 1'b0;
    end else if (strobe.armSet) begin
      armPend   <= 1'b1;
      clearPend <= 1'b0;
    end else if (strobe.clearSet) begin
      armPend   <= 1'b0;
      clearPend <= 1'b1;
    end
  end

  // nonvolatile protection bit: untouched by rst_n
  always_ff @(posedge clk) begin
    if (factoryInit) begin
      protOn <= 1'b0;
    end else if (strobe.periodEnd && armPend) begin
      protOn <= 1'b1;
    end else if (strobe.periodEnd && clearPend) begin
      protOn <= 1'b0;
    end
  end

endmodule

// File: rtl/wpseq_ctrl.sv
module wpseq_ctrl
  import wpseq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrValid,
  input  logic                pageEnd,
  input  logic [NUM_PATS-1:0] patHit,
  input  logic                protOn,
  output ctrlStrobe_t         strobe,
  output logic                commitOk,
  output logic                swallow,
  output seqState_t           seqState
);

  seqState_t nxtState;
  logic      plainOk;

  assign plainOk = !protOn;

  always_comb begin
    nxtState         = seqState;
    commitOk         = 1'b0;
    swallow          = 1'b0;
    strobe.armSet    = 1'b0;
    strobe.clearSet  = 1'b0;
    strobe.periodEnd = pageEnd;
    if (wrValid) begin
      unique case (seqState)
        ST_IDLE: begin
          if (patHit[HIT_KEYA]) begin
            swallow  = 1'b1;
            nxtState = ST_KEY1;
          end else begin
            commitOk = plainOk;
          end
        end
        ST_KEY1: begin
          if (patHit[HIT_KEYB]) begin
            swallow  = 1'b1;
            nxtState = ST_KEY2;
          end else begin
            commitOk = plainOk;
            nxtState = ST_IDLE;
          end
        end
        ST_KEY2: begin
          if (patHit[HIT_ARM]) begin
            swallow       = 1'b1;
            strobe.armSet = 1'b1;
            nxtState      = ST_OPEN;
          end else if (patHit[HIT_ERASE]) begin
            swallow  = 1'b1;
            nxtState = ST_DKEY1;
          end else begin
            commitOk = plainOk;
            nxtState = ST_IDLE;
          end
        end
        ST_DKEY1: begin
          if (patHit[HIT_KEYA]) begin
            swallow  = 1'b1;
            nxtState = ST_DKEY2;
          end else begin
            commitOk = plainOk;
            nxtState = ST_IDLE;
          end
        end
        ST_DKEY2: begin
          if (patHit[HIT_KEYB]) begin
            swallow  = 1'b1;
            nxtState = ST_DKEY3;
          end else begin
            commitOk = plainOk;
            nxtState = ST_IDLE;
          end
        end
        ST_DKEY3: begin
          if (patHit[HIT_CLEAR]) begin
            swallow         = 1'b1;
            strobe.clearSet = 1'b1;
            nxtState        = ST_OPEN;
          end else begin
            commitOk = plainOk;
            nxtState = ST_IDLE;
          end
        end
        ST_OPEN: begin
          commitOk = 1'b1;
        end
        default: begin
          nxtState = ST_IDLE;
        end
      endcase
    end
    // period end closes any window and drops any partial sequence
    if (pageEnd) begin
      nxtState        = ST_IDLE;
      strobe.armSet   = 1'b0;
      strobe.clearSet = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqState <= ST_IDLE;
    end else begin
      seqState <= nxtState;
    end
  end

endmodule

// File: rtl/wpseq_top.sv
module wpseq_top
  import wpseq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factoryInit,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pageEnd,
  output logic              commitOk,
  output logic              swallow,
  output logic              protOn
);

  logic [NUM_PATS-1:0] patHit;
  ctrlStrobe_t         strobe;
  seqState_t           seqState;

  wpseq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk),
    .rst_n(rst_n),
    .factoryInit(factoryInit),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strobe(strobe),
    .patHit(patHit),
    .protOn(protOn)
  );

  wpseq_ctrl ctrl_i (
    .clk(clk),
    .rst_n(rst_n),
    .wrValid(wrValid),
    .pageEnd(pageEnd),
    .patHit(patHit),
    .protOn(protOn),
    .strobe(strobe),
    .commitOk(commitOk),
    .swallow(swallow),
    .seqState(seqState)
  );

endmodule

// File: rtl/wpseq_chk.sv
module wpseq_chk
  import wpseq_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      factoryInit,
  input logic      wrValid,
  input logic      pageEnd,
  input logic      commitOk,
  input logic      swallow,
  input logic      protOn,
  input seqState_t seqState
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wrValid |-> (!commitOk && !swallow)); // R1

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(commitOk && swallow)); // R1

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pageEnd && !factoryInit) |=> $stable(protOn)); // R10

  AST_PAGE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    pageEnd |=> (seqState == ST_IDLE)); // R7

  AST_OPEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && seqState == ST_OPEN) |-> (commitOk && !swallow)); // R8

  AST_UNPROT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !protOn && !swallow) |-> commitOk); // R11

  AST_FACTORY_CLEAR: assert property (@(posedge clk)
    factoryInit |=> !protOn); // R9

endmodule

bind wpseq_top wpseq_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .factoryInit(factoryInit),
  .wrValid(wrValid),
  .pageEnd(pageEnd),
  .commitOk(commitOk),
  .swallow(swallow),
  .protOn(protOn),
  .seqState(seqState)
);

// File: tb/wpseq_top_tb.sv
module wpseq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        factoryInit = 1'b1;
  logic        wrValid = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        pageEnd = 1'b0;
  logic        commitOk;
  logic        swallow;
  logic        protOn;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .factoryInit(factoryInit),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .pageEnd(pageEnd),
    .commitOk(commitOk), .swallow(swallow), .protOn(protOn)
  );

  // row: {valid, pageEnd, addr, data, expCommit, expSwallow, expProt, reqNo}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 15'h0001, 8'h11, 1'b1, 1'b0, 1'b0, 4'd11}, //  0 R11 plain write commits
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd2},  //  1 R2
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd2},  //  2 R2
    {1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, 4'd2},  //  3 R2 arm
    {1'b1, 1'b0, 15'h0100, 8'h12, 1'b1, 1'b0, 1'b0, 4'd2},  //  4 R2 data in window
    {1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3},  //  5 R3 not yet on
    {1'b0, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd3},  //  6 R3 now on
    {1'b1, 1'b0, 15'h0002, 8'h34, 1'b0, 1'b0, 1'b1, 4'd4},  //  7 R4 blocked
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd2},  //  8 R2
    {1'b1, 1'b0, 15'h2AAA, 8'h77, 1'b0, 1'b0, 1'b1, 4'd6},  //  9 R6 break under protection
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd2},  // 10 R2
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd2},  // 11 R2
    {1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b1, 4'd2},  // 12 R2 unlock
    {1'b1, 1'b0, 15'h0003, 8'h56, 1'b1, 1'b0, 1'b1, 4'd2},  // 13 R2 unlocked data
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 1'b1, 4'd8},  // 14 R8 pattern as data
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b1, 4'd8},  // 15 R8
    {1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd7},  // 16 R7 window closes
    {1'b1, 1'b0, 15'h0004, 8'h78, 1'b0, 1'b0, 1'b1, 4'd7},  // 17 R7 blocked again
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd5},  // 18 R5
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd5},  // 19 R5
    {1'b1, 1'b0, 15'h5555, 8'h80, 1'b0, 1'b1, 1'b1, 4'd5},  // 20 R5
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd5},  // 21 R5
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd5},  // 22 R5
    {1'b1, 1'b0, 15'h5555, 8'h20, 1'b0, 1'b1, 1'b1, 4'd5},  // 23 R5 clear
    {1'b1, 1'b0, 15'h0005, 8'h9A, 1'b1, 1'b0, 1'b1, 4'd5},  // 24 R5 data commits
    {1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd10}, // 25 R10 unchanged before edge
    {1'b0, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // 26 R5 now off
    {1'b1, 1'b0, 15'h0006, 8'hBC, 1'b1, 1'b0, 1'b0, 4'd11}, // 27 R11
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd2},  // 28 R2
    {1'b1, 1'b0, 15'h1234, 8'h12, 1'b1, 1'b0, 1'b0, 4'd6},  // 29 R6 break when off
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd3},  // 30 R3
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd3},  // 31 R3
    {1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, 4'd3},  // 32 R3 arm, no data
    {1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3}   // 33 R3
  };

  task automatic drive(input logic v, input logic pe, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wrValid = v;
    pageEnd = pe;
    wrAddr  = a;
    wrData  = d;
    #(CLK_PERIOD/2 - 1);
  endtask

  task automatic check(input logic ec, input logic es, input logic ep, input int req, input string what);
    testsRun++;
    if (commitOk !== ec || swallow !== es || protOn !== ep) begin
      testsFail++;
      $display("FAIL R%0d %s: commitOk/swallow/protOn actual %b%b%b expected %b%b%b",
               req, what, commitOk, swallow, protOn, ec, es, ep);
    end
  endtask

  task automatic pulseReset();
    @(negedge clk);
    wrValid = 1'b0;
    pageEnd = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    factoryInit = 1'b0;
    rst_n = 1'b1;
    // R1 reset state, no write present
    drive(1'b0, 1'b0, 15'h0, 8'h0);
    check(1'b0, 1'b0, 1'b0, 1, "reset state");

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][31], VEC[i][30], VEC[i][29:15], VEC[i][14:7]);
      check(VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end
    // R3 arm without data took effect
    drive(1'b0, 1'b0, 15'h0, 8'h0);
    check(1'b0, 1'b0, 1'b1, 3, "armed without data");

    // R9 reset mid-window: window gone, protection kept
    drive(1'b1, 1'b0, 15'h5555, 8'hAA);
    drive(1'b1, 1'b0, 15'h2AAA, 8'h55);
    drive(1'b1, 1'b0, 15'h5555, 8'hA0);
    pulseReset();
    drive(1'b0, 1'b0, 15'h0, 8'h0);
    check(1'b0, 1'b0, 1'b1, 9, "protection survives reset");
    drive(1'b1, 1'b0, 15'h0007, 8'h01);
    check(1'b0, 1'b0, 1'b1, 9, "window cleared by reset");

    // R9 pending clear dropped by reset
    drive(1'b1, 1'b0, 15'h5555, 8'hAA);
    drive(1'b1, 1'b0, 15'h2AAA, 8'h55);
    drive(1'b1, 1'b0, 15'h5555, 8'h80);
    drive(1'b1, 1'b0, 15'h5555, 8'hAA);
    drive(1'b1, 1'b0, 15'h2AAA, 8'h55);
    drive(1'b1, 1'b0, 15'h5555, 8'h20);
    pulseReset();
    drive(1'b0, 1'b1, 15'h0, 8'h0);
    drive(1'b0, 1'b0, 15'h0, 8'h0);
    check(1'b0, 1'b0, 1'b1, 9, "pending clear dropped by reset");

    // R9 factory init clears protection
    drive(1'b0, 1'b0, 15'h0, 8'h0);
    factoryInit = 1'b1;
    drive(1'b0, 1'b0, 15'h0, 8'h0);
    factoryInit = 1'b0;
    check(1'b0, 1'b0, 1'b0, 9, "factory init");

    // R7 partial sequence discarded at page end
    drive(1'b1, 1'b0, 15'h5555, 8'hAA);
    drive(1'b1, 1'b0, 15'h2AAA, 8'h55);
    drive(1'b0, 1'b1, 15'h0, 8'h0);
    drive(1'b1, 1'b0, 15'h5555, 8'hA0);
    check(1'b1, 1'b0, 1'b0, 7, "partial sequence discarded");
    drive(1'b0, 1'b1, 15'h0, 8'h0);
    drive(1'b0, 1'b0, 15'h0, 8'h0);
    check(1'b0, 1'b0, 1'b0, 7, "no arm from discarded sequence");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      testsRun++;
      testsFail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule